// File: doc/BRIEF.md
# Multi-Mode Transmit Bit Framer

This block sits between a host that writes bytes and a modulator that takes one bit at a time. A two-bit mode input picks one of three ways to feed the modulator. In direct mode a host bit line goes straight to the serial output. In streaming mode, bytes written into a 64-byte FIFO are sent out MSB first, one bit per bit-clock enable, for as long as the host keeps the FIFO supplied. In packet mode the block builds a whole frame on its own around a payload taken from the FIFO, then raises a done pulse.

A packet frame starts with one to four 0xAA preamble bytes. A 32-bit sync word follows, then the payload bytes, then an optional CRC-16. Payload and CRC bits may be whitened for DC balance. The frame does not start until the FIFO holds the whole payload. The host therefore writes the payload bytes and then supplies bit-clock enables until done is seen.

Top module: `txf_tx_framer`

## Requirements
- R1: With mode = 00, tx_out equals direct_in combinationally. Bit enables then read nothing from the FIFO: fifo_full and fifo_empty keep their values.
- R2: With mode = 01, each cycle with bit_en high registers the next FIFO bit on tx_out, MSB first, with bytes in write order. The new bit is visible in the cycle after that edge.
- R3: In mode 01, if a new byte is needed at a bit_en while the FIFO is empty, underflow goes to 1 and tx_out is 0. Both hold until a bit_en finds data: that byte's MSB is then sent and underflow returns to 0.
- R4: Mode values 10 and 11 both select packet mode.
- R5: In packet mode no frame bit is sent until the FIFO holds at least pay_len bytes. Until then tx_out stays 0 and the FIFO is not read, even when bit_en is pulsed.
- R6: A packet frame is sent one bit per bit_en in this order. First come (pre_cfg+1) bytes of 0xAA, giving the bits 1,0,1,0,... Then sync_word goes out MSB first, followed by pay_len payload bytes MSB first.
- R7: When crc_en = 1, a CRC-16 is appended MSB first: polynomial 0x1021, start value 0xFFFF, bits fed MSB first, computed over the unwhitened payload only. When crc_en = 0, nothing is appended.
- R8: When white_en = 1, each payload and CRC bit is XORed with bit 0 of a 9-bit register. That register is set to 0x1FF at frame start and, after every payload or CRC bit, becomes {s[0]^s[5], s[8:1]}. Preamble and sync bits are never whitened.
- R9: The bit_en after the last frame bit makes done high for exactly one cycle and drives tx_out to 0. The block then returns to idle, with the payload bytes consumed from the FIFO.
- R10: The FIFO holds 64 bytes. fifo_full is 1 at 64 bytes. A write while full is dropped and leaves the FIFO contents unchanged.
- R11: After reset, with mode not 00: tx_out = 0, done = 0, underflow = 0, fifo_empty = 1, fifo_full = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 00 direct, 01 streaming, 1x packet |
| pre_cfg | input | 2 | Preamble byte count minus one |
| sync_word | input | 32 | Sync pattern, sent MSB first |
| crc_en | input | 1 | Append CRC-16 in packet mode |
| white_en | input | 1 | Whiten payload and CRC bits |
| pay_len | input | 7 | Payload byte count, 1 to 64 (other values act as 64) |
| wr_en | input | 1 | Write one byte into the FIFO |
| wr_data | input | 8 | Byte to write |
| fifo_full | output | 1 | FIFO holds 64 bytes |
| fifo_empty | output | 1 | FIFO holds no byte |
| bit_en | input | 1 | Bit-clock enable, one output bit per high cycle |
| direct_in | input | 1 | Host bit line for direct mode |
| tx_out | output | 1 | Serial bit to the modulator |
| done | output | 1 | One-cycle pulse at end of frame |
| underflow | output | 1 | Streaming mode ran out of data |

## Verification
The assertions take mode, pre_cfg, pay_len, crc_en, white_en and sync_word to be stable from the start of a frame until its done pulse, and mode to be stable while streaming. Under those conditions no payload read can hit an empty FIFO. The stimulus changes configuration only while reset is held or after a frame has ended. It also writes every payload in full before the frame's first bit enable.

// File: rtl/txf_pkg.sv
package txf_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_BUF, PH_PRE, PH_SYNC, PH_PAY, PH_CRC, PH_TAIL
  } txf_phase_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_INIT = 16'hFFFF;
  localparam logic [8:0]  WHT_INIT = 9'h1FF;

  // one MSB-first CRC-16 step for a single input bit
  function automatic logic [15:0] crc_bit_step(input logic [15:0] c, input logic b);
    return {c[14:0], 1'b0} ^ ((c[15] ^ b) ? CRC_POLY : 16'h0000);
  endfunction

  // one shift of the 9-bit whitening register
  function automatic logic [8:0] wht_shift(input logic [8:0] s);
    return {s[0] ^ s[5], s[8:1]};
  endfunction

endpackage

// File: rtl/txf_fifo.sv
module txf_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             wr_ok, rd_ok;

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign wr_ok   = wr_en && !full;
  assign rd_ok   = rd_en && !empty;
  assign rd_data = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wp <= (wp == PTR_LAST) ? '0 : wp + PTR_W'(1);
      if (rd_ok) rp <= (rp == PTR_LAST) ? '0 : rp + PTR_W'(1);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (count == $past(count))); // R10
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX); // R10

endmodule

// File: rtl/txf_framer_core.sv
module txf_framer_core
  import txf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int SYNC_W = 32,
  localparam int LEN_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH * 8 + 1),
  localparam int SB    = $clog2(SYNC_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [1:0]        pre_cfg,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              crc_en,
  input  logic              white_en,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              bit_en,
  input  logic [7:0]        rd_data,
  input  logic [LEN_W-1:0]  fifo_count,
  input  logic              fifo_empty,
  output logic              rd_en,
  output logic              tx_bit,
  output logic              done,
  output logic              underflow
);

  localparam logic [SB-1:0] SYNC_TOP = SB'(SYNC_W - 1);

  txf_phase_e       phase, next_phase;
  logic [IDX_W-1:0] idx, pre_end, pay_end;
  logic [7:0]       sh;
  logic [2:0]       rem;
  logic [15:0]      crc;
  logic [8:0]       lfsr;
  logic             tx_q, done_q, und_q;
  logic [LEN_W-1:0] len_eff;
  logic             buf_mode, pkt_start, raw_bit, out_bit, field_last, wht_field;
  logic             pay_pop, buf_pop;

  assign len_eff    = (pay_len == '0 || pay_len > LEN_W'(DEPTH)) ? LEN_W'(DEPTH) : pay_len;
  assign pre_end    = IDX_W'({pre_cfg, 3'b111});
  assign pay_end    = IDX_W'({len_eff - LEN_W'(1), 3'b111});
  assign buf_mode   = (mode == 2'b01);
  assign pkt_start  = (phase == PH_IDLE) && mode[1] && (fifo_count >= len_eff);
  assign wht_field  = (phase == PH_PAY) || (phase == PH_CRC);
  assign pay_pop    = (phase == PH_PAY) && bit_en && (idx[2:0] == 3'd0);
  assign buf_pop    = (phase == PH_BUF) && buf_mode && bit_en && (rem == 3'd0) && !fifo_empty;
  assign rd_en      = pay_pop || buf_pop;
  assign out_bit    = raw_bit ^ (white_en && wht_field && lfsr[0]);

  always_comb begin
    raw_bit    = 1'b0;
    field_last = 1'b0;
    next_phase = phase;
    case (phase)
      PH_PRE: begin
        raw_bit    = ~idx[0];
        field_last = (idx == pre_end);
        next_phase = PH_SYNC;
      end
      PH_SYNC: begin
        raw_bit    = sync_word[SYNC_TOP - idx[SB-1:0]];
        field_last = (idx == IDX_W'(SYNC_W - 1));
        next_phase = PH_PAY;
      end
      PH_PAY: begin
        raw_bit    = (idx[2:0] == 3'd0) ? rd_data[7] : sh[7];
        field_last = (idx == pay_end);
        next_phase = crc_en ? PH_CRC : PH_TAIL;
      end
      PH_CRC: begin
        raw_bit    = crc[4'd15 - idx[3:0]];
        field_last = (idx == IDX_W'(15));
        next_phase = PH_TAIL;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      idx    <= '0;
      sh     <= '0;
      rem    <= '0;
      crc    <= CRC_INIT;
      lfsr   <= WHT_INIT;
      tx_q   <= 1'b0;
      done_q <= 1'b0;
      und_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase)
        PH_IDLE: begin
          tx_q  <= 1'b0;
          und_q <= 1'b0;
          rem   <= '0;
          if (buf_mode) begin
            phase <= PH_BUF;
          end else if (pkt_start) begin
            phase <= PH_PRE;
            idx   <= '0;
            crc   <= CRC_INIT;
            lfsr  <= WHT_INIT;
          end
        end
        PH_BUF: begin
          if (!buf_mode) begin
            phase <= PH_IDLE;
            tx_q  <= 1'b0;
            und_q <= 1'b0;
          end else if (bit_en) begin
            if (rem != 3'd0) begin
              tx_q <= sh[7];
              sh   <= {sh[6:0], 1'b0};
              rem  <= rem - 3'd1;
            end else if (!fifo_empty) begin
              tx_q  <= rd_data[7];
              sh    <= {rd_data[6:0], 1'b0};
              rem   <= 3'd7;
              und_q <= 1'b0;
            end else begin
              tx_q  <= 1'b0;
              und_q <= 1'b1;
            end
          end
        end
        PH_TAIL: begin
          if (bit_en) begin
            tx_q   <= 1'b0;
            done_q <= 1'b1;
            phase  <= PH_IDLE;
          end
        end
        default: begin
          if (bit_en) begin
            tx_q <= out_bit;
            idx  <= field_last ? '0 : idx + IDX_W'(1);
            if (phase == PH_PAY) begin
              sh  <= (idx[2:0] == 3'd0) ? {rd_data[6:0], 1'b0} : {sh[6:0], 1'b0};
              crc <= crc_bit_step(crc, raw_bit);
            end
            if (wht_field) lfsr <= wht_shift(lfsr);
            if (field_last) phase <= next_phase;
          end
        end
      endcase
    end
  end

  assign tx_bit    = tx_q;
  assign done      = done_q;
  assign underflow = und_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_UNDER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    und_q |-> !tx_q); // R3
  AST_PAY_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    pay_pop |-> !fifo_empty); // R5
  AST_SYNC_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SYNC && $past(phase) != PH_SYNC) |-> ($past(phase) == PH_PRE)); // R6

endmodule

// File: rtl/txf_tx_framer.sv
module txf_tx_framer #(
  parameter int DEPTH  = 64,
  parameter int SYNC_W = 32,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [1:0]        pre_cfg,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              crc_en,
  input  logic              white_en,
  input  logic [LEN_W-1:0]  pay_len,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic              bit_en,
  input  logic              direct_in,
  output logic              tx_out,
  output logic              done,
  output logic              underflow
);

  logic             rd_en, core_tx;
  logic [7:0]       rd_data;
  logic [LEN_W-1:0] fifo_count;

  txf_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  txf_framer_core #(.DEPTH(DEPTH), .SYNC_W(SYNC_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pre_cfg(pre_cfg),
    .sync_word(sync_word), .crc_en(crc_en), .white_en(white_en),
    .pay_len(pay_len), .bit_en(bit_en), .rd_data(rd_data),
    .fifo_count(fifo_count), .fifo_empty(fifo_empty), .rd_en(rd_en),
    .tx_bit(core_tx), .done(done), .underflow(underflow)
  );

  assign tx_out = (mode == 2'b00) ? direct_in : core_tx;

endmodule

// File: tb/txf_tx_framer_test.sv
module txf_tx_framer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [1:0]  pre_cfg = 2'd0;
  logic [31:0] sync_word = 32'h2DD4_B17E;
  logic        crc_en = 1'b0, white_en = 1'b0;
  logic [6:0]  pay_len = 7'd1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        bit_en = 1'b0, direct_in = 1'b0;
  logic        fifo_full, fifo_empty, tx_out, done, underflow;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  bit exp_q[$];

  txf_tx_framer uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pre_cfg(pre_cfg),
    .sync_word(sync_word), .crc_en(crc_en), .white_en(white_en),
    .pay_len(pay_len), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .bit_en(bit_en),
    .direct_in(direct_in), .tx_out(tx_out), .done(done), .underflow(underflow)
  );

  always #4 clk = ~clk;

  // vector table: mode, preamble cfg, crc on, whiten on, length, expected frame bits
  localparam int NV = 5;
  localparam int V_MODE [NV] = '{2, 3, 2, 3, 2};
  localparam int V_PRE  [NV] = '{0, 3, 1, 2, 0};
  localparam int V_CRC  [NV] = '{1, 1, 0, 0, 1};
  localparam int V_WHT  [NV] = '{0, 1, 1, 0, 1};
  localparam int V_LEN  [NV] = '{1, 5, 3, 2, 64};
  localparam int V_BITS [NV] = '{64, 120, 72, 72, 568};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    wr_en = 1'b0; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step();
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk) begin wr_en = 1'b1; wr_data = b; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  function automatic logic [7:0] pay_byte(input int v, input int k);
    return 8'((k * 29) + (v * 71) + 5);
  endfunction

  function automatic logic [15:0] crc_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c ^ {b, 8'h00};
    for (int j = 0; j < 8; j++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic build(input int v);
    logic [15:0] c = 16'hFFFF;
    logic [8:0]  l = 9'h1FF;
    logic [7:0]  b;
    bit          wh = (V_WHT[v] != 0);
    exp_q.delete();
    for (int p = 0; p < (V_PRE[v] + 1) * 8; p++) exp_q.push_back((p % 2) == 0);
    for (int s = 31; s >= 0; s--) exp_q.push_back(sync_word[s]);
    for (int k = 0; k < V_LEN[v]; k++) begin
      b = pay_byte(v, k);
      c = crc_byte(c, b);
      for (int j = 7; j >= 0; j--) begin
        exp_q.push_back(b[j] ^ (wh & l[0]));
        l = {l[0] ^ l[5], l[8:1]};
      end
    end
    if (V_CRC[v] != 0)
      for (int j = 15; j >= 0; j--) begin
        exp_q.push_back(c[j] ^ (wh & l[0]));
        l = {l[0] ^ l[5], l[8:1]};
      end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin @(posedge clk); cyc++; end
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    logic [7:0] b;
    // R11 reset state
    mode = 2'b01;
    do_reset();
    @(negedge clk);
    chk("R11 tx_out", tx_out, 0);
    chk("R11 done", done, 0);
    chk("R11 underflow", underflow, 0);
    chk("R11 empty", fifo_empty, 1);
    chk("R11 full", fifo_full, 0);

    // packet vectors walked by one loop (R4 R5 R6 R7 R8 R9)
    for (int v = 0; v < NV; v++) begin
      mode = 2'(V_MODE[v]); pre_cfg = 2'(V_PRE[v]);
      crc_en = V_CRC[v][0]; white_en = V_WHT[v][0]; pay_len = 7'(V_LEN[v]);
      do_reset();
      build(v);
      chk("R6 frame length", exp_q.size(), V_BITS[v]);
      for (int k = 0; k < V_LEN[v] - 1; k++) push(pay_byte(v, k));
      if (V_LEN[v] > 1) begin
        repeat (3) step();
        chk("R5 no start before fill", tx_out, 0);
        chk("R5 fifo not read", fifo_empty, 0);
      end
      push(pay_byte(v, V_LEN[v] - 1));
      for (int i = 0; i < V_BITS[v]; i++) begin
        step();
        chk($sformatf("R6 R7 R8 R4 vec%0d bit%0d", v, i), tx_out, exp_q[i]);
        if (done) chk("R9 early done", done, 0);
      end
      step();
      chk("R9 done pulse", done, 1);
      chk("R9 tx low", tx_out, 0);
      @(negedge clk);
      chk("R9 done one cycle", done, 0);
      chk("R9 payload consumed", fifo_empty, 1);
    end

    // R2 R3 streaming mode
    mode = 2'b01;
    do_reset();
    push(8'hC3); push(8'h5A);
    for (int i = 0; i < 16; i++) begin
      b = (i < 8) ? 8'hC3 : 8'h5A;
      step();
      chk($sformatf("R2 bit%0d", i), tx_out, b[7 - (i % 8)]);
    end
    step();
    chk("R3 underflow set", underflow, 1);
    chk("R3 output low", tx_out, 0);
    push(8'h81);
    chk("R3 held until sent", underflow, 1);
    step();
    chk("R3 underflow cleared", underflow, 0);
    chk("R3 resumed msb", tx_out, 1);
    for (int i = 1; i < 8; i++) begin
      step();
      chk($sformatf("R2 resumed bit%0d", i), tx_out, (i == 7) ? 1 : 0);
    end

    // R1 direct mode and R10 full FIFO
    mode = 2'b00;
    do_reset();
    for (int k = 0; k < 64; k++) push(8'((k * 13) + 1));
    chk("R10 full at 64", fifo_full, 1);
    push(8'hFF);
    chk("R10 still full", fifo_full, 1);
    @(negedge clk) direct_in = 1'b1; #1;
    chk("R1 pass high", tx_out, 1);
    @(negedge clk) direct_in = 1'b0; #1;
    chk("R1 pass low", tx_out, 0);
    repeat (4) step();
    chk("R1 no read full", fifo_full, 1);
    chk("R1 no read empty", fifo_empty, 0);
    @(negedge clk) mode = 2'b01;
    for (int k = 0; k < 64; k++) begin
      b = 8'((k * 13) + 1);
      for (int j = 7; j >= 0; j--) begin
        step();
        chk($sformatf("R10 R2 byte%0d bit%0d", k, j), tx_out, b[j]);
      end
    end
    step();
    chk("R10 extra write dropped", underflow, 1);
    chk("R10 empty after drain", fifo_empty, 1);
    summary();
  end

endmodule